// File: doc/BRIEF.md
# Timer Compare Match Unit

This unit sits next to a 16-bit free-running timer and watches its count. Software loads a 16-bit compare value as two separate byte writes and picks an action through a 4-bit mode field. Whenever the timer count becomes equal to the compare value, the unit does one of four things. It can set an output latch, clear that latch, or only raise an interrupt flag. In trigger mode it pulses a timer-clear and an ADC-start request, so the compare value acts as the timer's period.

The count input must come from a timer that runs in the same clock domain. A count that arrives asynchronously can skip over the compare value, and the match is then missed. Every output is registered, so an action is visible one clock after the cycle in which the count equals the compare value. The pin output passes through a direction gate. When the gate selects input, the pin is released, but the internal latch keeps its value.

Top module: `cmp_match_unit`

## Requirements
- R1: Writes to address 0 and address 1 load the low and high byte of the compare value. The value is checked against `tmr_count` on every cycle, and any resulting action appears on the outputs one clock after the equal cycle.
- R2: Every match in an active mode sets `irq_flag` on the same clock edge that applies the pin action.
- R3: Mode code 4'b1010 sets only the interrupt flag on a match, and the compare latch keeps its value.
- R4: Mode code 4'b1011 makes a match pulse `tmr_clear` and `adc_start` high together for exactly one cycle. The latch is left unchanged.
- R5: A write to the control register (address 2) whose mode field, bits [3:0], is zero forces the compare latch low.
- R6: A match fires once per new equality. Holding the count equal to the compare value repeats no action.
- R7: The interrupt flag stays set until a write to address 3 with bit 0 set. If such a write lands in the same cycle as a new match, the flag stays set.
- R8: Mode code 4'b1000 drives the latch high on a match and 4'b1001 drives it low. A mode code outside 4'b1000 to 4'b1011 produces no action at all.
- R9: Control bit 7 set to 1 releases the pin: `pin_oe` is 0 and `pin_out` is 0. The latch keeps its value and reappears when bit 7 returns to 0.
- R10: After reset, all outputs are low except `pin_oe`, which is 1. The compare value and the mode are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 control, 3 flag clear |
| wr_data | input | 8 | Write data |
| tmr_count | input | 16 | Current timer count |
| tmr_clear | output | 1 | One-cycle request to reset the timer to zero |
| adc_start | output | 1 | One-cycle request to start an ADC conversion |
| pin_out | output | 1 | Compare pin level, gated by direction |
| pin_oe | output | 1 | Pin drive enable |
| irq_flag | output | 1 | Sticky compare interrupt flag |

## Verification
The bench provokes two kinds of same-cycle collision. In the first, software clears the flag in the same cycle as a new match. The bench writes the clear while stepping the count onto the compare value in that same cycle, and the flag must stay set afterwards. In the second, a pin action and a flag change fall on one edge. Here the bench checks after that edge that both the pin level and the flag have their required values. A reference model in the driver predicts every output, and the monitor compares the design against it after each edge.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int BYTE_W = 8;
  localparam int MODE_W = 4;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_LO   = 2'd0;
  localparam logic [ADDR_W-1:0] A_HI   = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;
  localparam logic [ADDR_W-1:0] A_FCLR = 2'd3;

  localparam logic [MODE_W-1:0] M_HIGH = 4'b1000;
  localparam logic [MODE_W-1:0] M_LOW  = 4'b1001;
  localparam logic [MODE_W-1:0] M_SWI  = 4'b1010;
  localparam logic [MODE_W-1:0] M_TRIG = 4'b1011;

  localparam int DIR_BIT = 7;

  function automatic logic mode_active(input logic [MODE_W-1:0] m);
    return m[3:2] == 2'b10;
  endfunction
endpackage

// File: rtl/cmp_regs.sv
module cmp_regs
  import cmp_pkg::*;
#(
  parameter int NBYTES = 2,
  localparam int CW = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CW-1:0]     cmp_val,
  output logic [MODE_W-1:0] mode,
  output logic              dir_in,
  output logic              ctrl_zero_wr,
  output logic              flag_clr_wr
);
  genvar gi;
  generate
    for (gi = 0; gi < NBYTES; gi++) begin : g_byte
      always_ff @(posedge clk) begin
        if (rst)
          cmp_val[gi*BYTE_W +: BYTE_W] <= '0;
        else if (wr_en && wr_addr == ADDR_W'(gi))
          cmp_val[gi*BYTE_W +: BYTE_W] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= '0;
      dir_in <= 1'b0;
    end else if (wr_en && wr_addr == A_CTRL) begin
      mode   <= wr_data[MODE_W-1:0];
      dir_in <= wr_data[DIR_BIT];
    end
  end

  always_comb begin
    ctrl_zero_wr = wr_en && wr_addr == A_CTRL && wr_data[MODE_W-1:0] == '0;
    flag_clr_wr  = wr_en && wr_addr == A_FCLR && wr_data[0];
  end
endmodule

// File: rtl/cmp_detect.sv
module cmp_detect
  import cmp_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     cmp_val,
  input  logic [CW-1:0]     tmr_count,
  input  logic [MODE_W-1:0] mode,
  output logic              hit_edge
);
  logic equal_now;
  logic equal_prev;

  always_comb begin
    equal_now = mode_active(mode) && (tmr_count == cmp_val);
    hit_edge  = equal_now && !equal_prev;
  end

  always_ff @(posedge clk) begin
    if (rst) equal_prev <= 1'b0;
    else     equal_prev <= equal_now;
  end

  assert_edge_once_R6: assert property (@(posedge clk) disable iff (rst)
    hit_edge |=> !hit_edge);
endmodule

// File: rtl/cmp_action.sv
module cmp_action
  import cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_edge,
  input  logic [MODE_W-1:0] mode,
  input  logic              ctrl_zero_wr,
  input  logic              flag_clr_wr,
  output logic              latch_q,
  output logic              irq_flag,
  output logic              tmr_clear,
  output logic              adc_start
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q   <= 1'b0;
      irq_flag  <= 1'b0;
      tmr_clear <= 1'b0;
      adc_start <= 1'b0;
    end else begin
      if (hit_edge)         irq_flag <= 1'b1;
      else if (flag_clr_wr) irq_flag <= 1'b0;

      if (ctrl_zero_wr)                      latch_q <= 1'b0;
      else if (hit_edge && mode == M_HIGH)   latch_q <= 1'b1;
      else if (hit_edge && mode == M_LOW)    latch_q <= 1'b0;

      tmr_clear <= hit_edge && mode == M_TRIG;
      adc_start <= hit_edge && mode == M_TRIG;
    end
  end

  assert_flag_on_match_R2: assert property (@(posedge clk) disable iff (rst)
    hit_edge |=> irq_flag);
  assert_swi_keeps_latch_R3: assert property (@(posedge clk) disable iff (rst)
    (hit_edge && mode == M_SWI && !ctrl_zero_wr) |=> latch_q == $past(latch_q));
  assert_trig_pair_R4: assert property (@(posedge clk) disable iff (rst)
    tmr_clear |-> adc_start);
  assert_trig_single_R4: assert property (@(posedge clk) disable iff (rst)
    tmr_clear |=> !tmr_clear);
  assert_zero_ctrl_low_R5: assert property (@(posedge clk) disable iff (rst)
    ctrl_zero_wr |=> !latch_q);
endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit
  import cmp_pkg::*;
#(
  parameter int NBYTES = 2,
  localparam int CW = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [CW-1:0]     tmr_count,
  output logic              tmr_clear,
  output logic              adc_start,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              irq_flag
);
  logic [CW-1:0]     cmp_val;
  logic [MODE_W-1:0] mode;
  logic              dir_in;
  logic              ctrl_zero_wr;
  logic              flag_clr_wr;
  logic              hit_edge;
  logic              latch_q;

  cmp_regs #(.NBYTES(NBYTES)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmp_val(cmp_val), .mode(mode), .dir_in(dir_in),
    .ctrl_zero_wr(ctrl_zero_wr), .flag_clr_wr(flag_clr_wr)
  );

  cmp_detect #(.CW(CW)) u_detect (
    .clk(clk), .rst(rst), .cmp_val(cmp_val), .tmr_count(tmr_count),
    .mode(mode), .hit_edge(hit_edge)
  );

  cmp_action u_action (
    .clk(clk), .rst(rst), .hit_edge(hit_edge), .mode(mode),
    .ctrl_zero_wr(ctrl_zero_wr), .flag_clr_wr(flag_clr_wr),
    .latch_q(latch_q), .irq_flag(irq_flag),
    .tmr_clear(tmr_clear), .adc_start(adc_start)
  );

  always_comb begin
    pin_oe  = !dir_in;
    pin_out = latch_q && !dir_in;
  end

  assert_released_pin_R9: assert property (@(posedge clk) disable iff (rst)
    !pin_oe |-> !pin_out);
endmodule

// File: tb/cmp_match_unit_bench.sv
module cmp_match_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] tmr_count = '0;
  logic        tmr_clear, adc_start, pin_out, pin_oe, irq_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cmp_match_unit u_cmp_match_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tmr_count(tmr_count), .tmr_clear(tmr_clear), .adc_start(adc_start),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_flag(irq_flag)
  );

  typedef struct {
    string tag;
    logic  pin, oe, flag, clr, adc;
  } exp_t;
  exp_t exp_q[$];

  logic [15:0] m_cmp = '0;
  logic [3:0]  m_mode = '0;
  logic        m_dir = 1'b0, m_latch = 1'b0, m_flag = 1'b0, m_prev = 1'b0;

  task automatic chk(input string tag, input string what, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, expv);
    end
  endtask

  task automatic step(input string tag, input logic we, input logic [1:0] a,
                      input logic [7:0] d, input logic [15:0] cnt);
    logic hit, edge_now, zero;
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; tmr_count = cnt;
    hit      = (m_mode[3:2] == 2'b10) && (cnt == m_cmp);
    edge_now = hit && !m_prev;
    zero     = we && a == 2'd2 && d[3:0] == 4'd0;
    if (edge_now) m_flag = 1'b1;
    else if (we && a == 2'd3 && d[0]) m_flag = 1'b0;
    if (zero) m_latch = 1'b0;
    else if (edge_now && m_mode == 4'b1000) m_latch = 1'b1;
    else if (edge_now && m_mode == 4'b1001) m_latch = 1'b0;
    e.clr = edge_now && m_mode == 4'b1011;
    e.adc = e.clr;
    m_prev = hit;
    if (we) begin
      case (a)
        2'd0: m_cmp[7:0]  = d;
        2'd1: m_cmp[15:8] = d;
        2'd2: begin m_mode = d[3:0]; m_dir = d[7]; end
        default: ;
      endcase
    end
    e.tag  = tag;
    e.flag = m_flag;
    e.oe   = !m_dir;
    e.pin  = m_latch && !m_dir;
    exp_q.push_back(e);
  endtask

  task automatic wr(input string tag, input logic [1:0] a, input logic [7:0] d,
                    input logic [15:0] cnt);
    step(tag, 1'b1, a, d, cnt);
  endtask

  task automatic tick(input string tag, input logic [15:0] cnt);
    step(tag, 1'b0, 2'd0, 8'd0, cnt);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        chk(e.tag, "pin_out",   pin_out,   e.pin);
        chk(e.tag, "pin_oe",    pin_oe,    e.oe);
        chk(e.tag, "irq_flag",  irq_flag,  e.flag);
        chk(e.tag, "tmr_clear", tmr_clear, e.clr);
        chk(e.tag, "adc_start", adc_start, e.adc);
      end
    end
  end

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    chk("R10", "pin_out",   pin_out,   1'b0);
    chk("R10", "pin_oe",    pin_oe,    1'b1);
    chk("R10", "irq_flag",  irq_flag,  1'b0);
    chk("R10", "tmr_clear", tmr_clear, 1'b0);
    chk("R10", "adc_start", adc_start, 1'b0);
    rst = 1'b0;
    tick("R10", 16'h0000);
    wr("R1", 2'd0, 8'h34, 16'h0000);
    wr("R1", 2'd1, 8'h12, 16'h0000);
    wr("R8", 2'd2, 8'h08, 16'h0000);
    tick("R1", 16'h1233);
    tick("R2", 16'h1234);
    tick("R6", 16'h1234);
    tick("R6", 16'h1234);
    tick("R6", 16'h1235);
    wr("R7", 2'd3, 8'h01, 16'h1200);
    wr("R8", 2'd2, 8'h09, 16'h0000);
    tick("R8", 16'h1234);
    wr("R6", 2'd3, 8'h01, 16'h1234);
    wr("R8", 2'd2, 8'h08, 16'h0000);
    tick("R2", 16'h1234);
    wr("R3", 2'd2, 8'h0A, 16'h0000);
    wr("R7", 2'd3, 8'h01, 16'h0000);
    tick("R3", 16'h1234);
    tick("R3", 16'h0000);
    wr("R7", 2'd3, 8'h01, 16'h0000);
    wr("R7", 2'd3, 8'h01, 16'h1234);
    tick("R7", 16'h0001);
    wr("R4", 2'd2, 8'h0B, 16'h0000);
    wr("R4", 2'd3, 8'h01, 16'h0000);
    tick("R4", 16'h1234);
    tick("R4", 16'h0000);
    tick("R4", 16'h0001);
    wr("R8", 2'd2, 8'h05, 16'h0000);
    wr("R8", 2'd3, 8'h01, 16'h0000);
    tick("R8", 16'h1234);
    tick("R8", 16'h0000);
    wr("R9", 2'd2, 8'h88, 16'h0000);
    tick("R9", 16'h0002);
    wr("R9", 2'd2, 8'h08, 16'h0000);
    wr("R9", 2'd2, 8'h89, 16'h0000);
    tick("R9", 16'h1234);
    wr("R9", 2'd2, 8'h08, 16'h0000);
    tick("R8", 16'h1234);
    wr("R5", 2'd2, 8'h00, 16'h0000);
    tick("R5", 16'h1234);
    wr("R1", 2'd1, 8'h00, 16'h0000);
    wr("R1", 2'd2, 8'h08, 16'h0000);
    tick("R1", 16'h1234);
    tick("R1", 16'h0034);
    tick("R1", 16'h0000);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule